// File: doc/BRIEF.md
# Bus Byte-Lane Steering Unit

This unit sits between a 32-bit host data bus and a bus interface that acts both as a bus master and as a bus slave. It handles four kinds of transfer:

- **Outgoing data** (master writes and slave reads). The unit takes right-aligned internal data and moves each byte onto the proper bus lane. The lane is chosen from a two-bit software pointer and the access size. The unit also produces active-low lane enables.
- **Mirroring for 386-class buses.** When a byte or 16-bit access touches the upper half of the bus, its bytes are also copied into the matching lower-half lanes. Data that lies only in the lower half is never copied.
- **Incoming data** (master reads and slave writes). The unit picks out only the addressed bytes and right-aligns them for the internal side.
- **Byte reversal.** A swap mode bit reverses the bytes of a master write within the access unit, for big-endian hosts. Every other transfer type ignores it.

A request is presented for one cycle with `req_valid`. All results appear registered one cycle later, together with `rsp_valid`. They hold their value until the next request. Misaligned or malformed requests are reported on `rsp_err`, and for them the unit drives no enables and no data.

Top module: `lane_steer`

## Requirements
- R1: One cycle after `req_valid` is high, `rsp_valid` is high and all outputs reflect that request. In a cycle that follows a low `req_valid`, `rsp_valid` is low and `bus_dout`, `bus_be_n`, `int_rdata` and `rsp_err` keep their previous values. After reset: `rsp_valid`=0, `bus_be_n`=4'b1111, `bus_dout`=0, `int_rdata`=0, `rsp_err`=0.
- R2: Encodings.
  - `req_op`: 2'b00 = master write, 2'b01 = slave read, 2'b10 = master read, 2'b11 = slave write.
  - `req_size`: 2'b00 = one byte, 2'b01 = 16 bits, 2'b10 = 32 bits, 2'b11 = invalid.
  - `req_ptr`: the starting lane (0..3). Lane k is `bus_dout[8k+7:8k]`.
- R3: For master write, slave read and slave write, `bus_be_n[i]` is 0 exactly for lanes `req_ptr` through `req_ptr`+n-1, where n is 1, 2 or 4 bytes. All other enable bits are 1.
- R4: On a master read that is not in error, `bus_be_n` is 4'b0000, whatever the pointer and size are.
- R5: On outgoing transfers without reversal, byte k of `int_wdata` (k < n) appears on lane `req_ptr`+k.
- R6: For outgoing byte or 16-bit accesses, every active lane in the upper half (lane 2 or 3) whose lower partner (lane 0 or 1) is inactive has its byte copied onto that lower partner.
- R7: Lanes that are neither active nor filled by a copy are driven as zero. An access that lies wholly in lanes 0–1 produces no copies, and a 32-bit access produces none either.
- R8: On a master write with `swap_mode`=1, the n bytes are reversed before placement. Byte k of the access takes `int_wdata` byte n-1-k. A single byte is unchanged.
- R9: `swap_mode` has no effect on slave reads, master reads or slave writes.
- R10: On incoming transfers, byte k (k < n) of `int_rdata` equals lane `req_ptr`+k of `bus_din`. Bytes k >= n are zero. Bus lanes outside the addressed range do not affect the result.
- R11: A request with `req_size`=2'b11, a 16-bit access at pointer 3, or a 32-bit access at a nonzero pointer sets `rsp_err`=1. For such a request, `bus_be_n`=4'b1111, `bus_dout`=0 and `int_rdata`=0.
- R12: `bus_dout` is zero on incoming transfers. `int_rdata` is zero on outgoing transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Transfer kind (R2) |
| req_size | input | 2 | Access size (R2) |
| req_ptr | input | 2 | Low pointer bits selecting the start lane |
| swap_mode | input | 1 | Byte-reversal mode for master writes |
| int_wdata | input | 32 | Right-aligned internal data for outgoing transfers |
| bus_din | input | 32 | Data sampled from the host bus for incoming transfers |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| bus_dout | output | 32 | Lane-steered data for the host bus |
| bus_be_n | output | 4 | Active-low lane enables |
| int_rdata | output | 32 | Right-aligned data extracted from the bus |
| rsp_err | output | 1 | Misaligned or invalid access |

## Verification
The hardest cases to reach are those where the lane enables and the data lanes follow different rules:

- A master read with a partial pointer, where all four enables are on but only a few bytes may be kept.
- A 16-bit access at pointer 1, which straddles the two halves of the bus, so exactly one byte is copied down.

To reach them, the stimulus sweeps every combination of operation, size, pointer and swap bit. Each combination gets fresh random bytes on all lanes, so a lane taken from the wrong place or leaking into the result shows up. The sweep is followed by random requests with idle gaps, to exercise the holding behaviour. A behavioural model predicts every output on every clock.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

   // Transfer kinds (R2)
   typedef enum logic [1:0] {
      OP_MWR = 2'b00,
      OP_SRD = 2'b01,
      OP_MRD = 2'b10,
      OP_SWR = 2'b11
   } op_e;

   // Access sizes (R2)
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_FULL = 2'b10,
      SZ_BAD  = 2'b11
   } size_e;

   function automatic logic op_is_out(op_e op);
      return (op == OP_MWR) || (op == OP_SRD);
   endfunction

endpackage

// File: rtl/lane_decode.sv
module lane_decode
   import lane_steer_pkg::*;
#(
   parameter int NLANES = 4,
   localparam int PTR_W = $clog2(NLANES),
   localparam int CNT_W = $clog2(NLANES) + 1
) (
   input  logic [PTR_W-1:0]  ptr,
   input  size_e             size,
   output logic [CNT_W-1:0]  cnt,
   output logic [NLANES-1:0] lane_act,
   output logic              err
);

   logic             bad_code;
   logic [CNT_W-1:0] span_end;

   always_comb begin
      bad_code = 1'b0;
      unique case (size)
         SZ_BYTE: cnt = CNT_W'(1);
         SZ_HALF: cnt = CNT_W'(2);
         SZ_FULL: cnt = CNT_W'(NLANES);
         default: begin
            cnt      = '0;
            bad_code = 1'b1;
         end
      endcase
      span_end = {1'b0, ptr} + cnt;
      err      = bad_code || (span_end > CNT_W'(NLANES));
   end

   for (genvar i = 0; i < NLANES; i++) begin : g_act
      assign lane_act[i] = !err
                           && (CNT_W'(i) >= {1'b0, ptr})
                           && (CNT_W'(i) < span_end);
   end

endmodule

// File: rtl/lane_pack.sv
module lane_pack #(
   parameter int NLANES  = 4,
   parameter int LANE_W  = 8,
   parameter bit SWAP_EN = 1'b1,
   parameter bit DUP_EN  = 1'b1,
   localparam int DW     = NLANES * LANE_W,
   localparam int PTR_W  = $clog2(NLANES),
   localparam int CNT_W  = $clog2(NLANES) + 1,
   localparam int HALF   = NLANES / 2
) (
   input  logic [DW-1:0]     src,
   input  logic [PTR_W-1:0]  ptr,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [NLANES-1:0] lane_act,
   input  logic              do_swap,
   output logic [DW-1:0]     lanes_out
);

   logic [LANE_W-1:0] src_b  [NLANES];
   logic [LANE_W-1:0] ord_b  [NLANES];
   logic [LANE_W-1:0] plc_b  [NLANES];
   logic [LANE_W-1:0] fin_b  [NLANES];

   for (genvar k = 0; k < NLANES; k++) begin : g_split
      assign src_b[k] = src[k*LANE_W +: LANE_W];
   end

   // Optional reversal of the access unit
   if (SWAP_EN) begin : g_swap
      always_comb begin
         for (int k = 0; k < NLANES; k++) begin
            if (do_swap && (CNT_W'(k) < cnt))
               ord_b[k] = src_b[PTR_W'(cnt - CNT_W'(1)) - PTR_W'(k)];
            else
               ord_b[k] = src_b[k];
         end
      end
   end else begin : g_noswap
      logic unused_swap;
      assign unused_swap = do_swap;
      assign ord_b = src_b;
   end

   // Shift onto the addressed lanes, zero elsewhere
   always_comb begin
      for (int i = 0; i < NLANES; i++) begin
         if (lane_act[i])
            plc_b[i] = ord_b[PTR_W'(i) - ptr];
         else
            plc_b[i] = '0;
      end
   end

   // Upper-half to lower-half mirroring for narrow accesses
   if (DUP_EN) begin : g_dup
      logic narrow;
      assign narrow = (cnt < CNT_W'(NLANES));
      for (genvar i = 0; i < NLANES; i++) begin : g_lane
         if (i < HALF) begin : g_low
            assign fin_b[i] = (!lane_act[i] && narrow && lane_act[i+HALF])
                              ? plc_b[i+HALF] : plc_b[i];
         end else begin : g_high
            assign fin_b[i] = plc_b[i];
         end
      end
   end else begin : g_nodup
      assign fin_b = plc_b;
   end

   for (genvar k = 0; k < NLANES; k++) begin : g_join
      assign lanes_out[k*LANE_W +: LANE_W] = fin_b[k];
   end

endmodule

// File: rtl/lane_unpack.sv
module lane_unpack #(
   parameter int NLANES = 4,
   parameter int LANE_W = 8,
   localparam int DW    = NLANES * LANE_W,
   localparam int PTR_W = $clog2(NLANES),
   localparam int CNT_W = $clog2(NLANES) + 1
) (
   input  logic [DW-1:0]    bus,
   input  logic [PTR_W-1:0] ptr,
   input  logic [CNT_W-1:0] cnt,
   output logic [DW-1:0]    aligned
);

   logic [LANE_W-1:0] bus_b [NLANES];

   for (genvar k = 0; k < NLANES; k++) begin : g_split
      assign bus_b[k] = bus[k*LANE_W +: LANE_W];
   end

   always_comb begin
      for (int k = 0; k < NLANES; k++) begin
         if ((CNT_W'(k) < cnt) && ((CNT_W'(k) + {1'b0, ptr}) < CNT_W'(NLANES)))
            aligned[k*LANE_W +: LANE_W] = bus_b[PTR_W'(k) + ptr];
         else
            aligned[k*LANE_W +: LANE_W] = '0;
      end
   end

endmodule

// File: rtl/lane_steer.sv
module lane_steer
   import lane_steer_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int LANE_W  = 8,
   parameter bit SWAP_EN = 1'b1,
   parameter bit DUP_EN  = 1'b1,
   localparam int NLANES = DATA_W / LANE_W,
   localparam int PTR_W  = $clog2(NLANES),
   localparam int CNT_W  = $clog2(NLANES) + 1,
   localparam int HALF   = NLANES / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [1:0]        req_size,
   input  logic [PTR_W-1:0]  req_ptr,
   input  logic              swap_mode,
   input  logic [DATA_W-1:0] int_wdata,
   input  logic [DATA_W-1:0] bus_din,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] bus_dout,
   output logic [NLANES-1:0] bus_be_n,
   output logic [DATA_W-1:0] int_rdata,
   output logic              rsp_err
);

   // Elaboration-time parameter checks
   if (DATA_W % LANE_W != 0) begin : g_chk_div
      $error("DATA_W must be a multiple of LANE_W");
   end
   if (NLANES < 4 || (NLANES & (NLANES - 1)) != 0) begin : g_chk_lanes
      $error("lane count must be a power of two, at least 4");
   end

   op_e   op;
   size_e size;
   logic  is_out;
   logic  do_swap;

   assign op      = op_e'(req_op);
   assign size    = size_e'(req_size);
   assign is_out  = op_is_out(op);
   assign do_swap = swap_mode && (op == OP_MWR);

   logic [CNT_W-1:0]  cnt;
   logic [NLANES-1:0] lane_act;
   logic              err;
   logic [DATA_W-1:0] packed_d;
   logic [DATA_W-1:0] unpacked_d;

   lane_decode #(.NLANES(NLANES)) u_decode (
      .ptr      (req_ptr),
      .size     (size),
      .cnt      (cnt),
      .lane_act (lane_act),
      .err      (err)
   );

   lane_pack #(
      .NLANES  (NLANES),
      .LANE_W  (LANE_W),
      .SWAP_EN (SWAP_EN),
      .DUP_EN  (DUP_EN)
   ) u_pack (
      .src       (int_wdata),
      .ptr       (req_ptr),
      .cnt       (cnt),
      .lane_act  (lane_act),
      .do_swap   (do_swap),
      .lanes_out (packed_d)
   );

   lane_unpack #(
      .NLANES (NLANES),
      .LANE_W (LANE_W)
   ) u_unpack (
      .bus     (bus_din),
      .ptr     (req_ptr),
      .cnt     (cnt),
      .aligned (unpacked_d)
   );

   logic [NLANES-1:0] be_n_d;
   logic [DATA_W-1:0] dout_d;
   logic [DATA_W-1:0] rdat_d;

   always_comb begin
      if (err)                be_n_d = '1;
      else if (op == OP_MRD)  be_n_d = '0;
      else                    be_n_d = ~lane_act;
      dout_d = (is_out && !err)  ? packed_d   : '0;
      rdat_d = (!is_out && !err) ? unpacked_d : '0;
   end

   op_e   op_q;
   size_e size_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         bus_dout  <= '0;
         bus_be_n  <= '1;
         int_rdata <= '0;
         rsp_err   <= 1'b0;
         op_q      <= OP_MWR;
         size_q    <= SZ_BYTE;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            bus_dout  <= dout_d;
            bus_be_n  <= be_n_d;
            int_rdata <= rdat_d;
            rsp_err   <= err;
            op_q      <= op;
            size_q    <= size;
         end
      end
   end

   // Assertions
   assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && $stable(bus_dout) && $stable(bus_be_n)
                      && $stable(int_rdata) && $stable(rsp_err)));

   assert_mrd_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && op_q == OP_MRD && !rsp_err) |-> (bus_be_n == '0));

   assert_err_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (bus_be_n == '1 && bus_dout == '0 && int_rdata == '0));

   assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && size_q == SZ_BYTE && op_q != OP_MRD && !rsp_err)
      |-> ($countones(~bus_be_n) == 1));

   assert_other_path_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !op_is_out(op_q)) |-> (bus_dout == '0));

   if (DUP_EN) begin : g_dup_chk
      assert_upper_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && op_is_out(op_q) && size_q != SZ_FULL && !rsp_err
          && !bus_be_n[NLANES-1])
         |-> (bus_dout[(HALF-1)*LANE_W +: LANE_W] == bus_dout[(NLANES-1)*LANE_W +: LANE_W]));
   end

endmodule

// File: tb/lane_steer_tb.sv
`timescale 1ns/1ps
module lane_steer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'b00;
   logic [1:0]  req_size = 2'b00;
   logic [1:0]  req_ptr = 2'b00;
   logic        swap_mode = 1'b0;
   logic [31:0] int_wdata = '0;
   logic [31:0] bus_din = '0;
   logic        rsp_valid;
   logic [31:0] bus_dout;
   logic [3:0]  bus_be_n;
   logic [31:0] int_rdata;
   logic        rsp_err;

   always #2.5 clk = ~clk;

   lane_steer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_size  (req_size),
      .req_ptr   (req_ptr),
      .swap_mode (swap_mode),
      .int_wdata (int_wdata),
      .bus_din   (bus_din),
      .rsp_valid (rsp_valid),
      .bus_dout  (bus_dout),
      .bus_be_n  (bus_be_n),
      .int_rdata (int_rdata),
      .rsp_err   (rsp_err)
   );

   int vectors = 0;
   int fails   = 0;

   // Expected state (reset values, R1)
   bit          e_valid = 0;
   bit          e_err   = 0;
   logic [3:0]  e_be    = 4'hF;
   logic [31:0] e_dout  = '0;
   logic [31:0] e_rdat  = '0;
   int          e_op    = 0;
   bit          e_swap  = 0;

   // Behavioural model; op codes per R2: 0 MWR, 1 SRD, 2 MRD, 3 SWR
   task automatic model(input int op, input int sz, input int ptr, input bit sw,
                        input logic [31:0] wd, input logic [31:0] rd);
      int n;
      bit act [4];
      logic [7:0] ln [4];
      n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
      e_valid = 1; e_op = op; e_swap = sw;
      e_err = (n == 0) || (ptr + n > 4);
      e_dout = '0; e_rdat = '0; e_be = 4'hF;
      if (e_err) return;
      for (int i = 0; i < 4; i++) begin
         act[i] = (i >= ptr) && (i < ptr + n);
         e_be[i] = (op == 2) ? 1'b0 : !act[i];
         ln[i] = '0;
      end
      if (op <= 1) begin
         for (int k = 0; k < n; k++)
            ln[ptr+k] = (op == 0 && sw) ? wd[8*(n-1-k) +: 8] : wd[8*k +: 8];
         if (n < 4)
            for (int j = 2; j < 4; j++)
               if (act[j] && !act[j-2]) ln[j-2] = ln[j];
         for (int i = 0; i < 4; i++) e_dout[8*i +: 8] = ln[i];
      end else begin
         for (int k = 0; k < n; k++) e_rdat[8*k +: 8] = rd[8*(ptr+k) +: 8];
      end
   endtask

   function automatic string tag_dout();
      if (e_err)           return "R11";
      if (e_op >= 2)       return "R12";
      if (e_op == 0 && e_swap) return "R8";
      if (e_op == 1 && e_swap) return "R9";
      return "R5/R6/R7";
   endfunction

   function automatic string tag_be();
      if (e_err)     return "R11";
      if (e_op == 2) return "R4";
      return "R3";
   endfunction

   function automatic string tag_rdat();
      if (e_err)     return "R11";
      if (e_op <= 1) return "R12";
      if (e_swap)    return "R9";
      return "R10";
   endfunction

   task automatic compare();
      vectors++;
      if (rsp_valid !== e_valid) begin
         fails++; $display("FAIL R1 rsp_valid act=%0b exp=%0b", rsp_valid, e_valid);
      end
      if (rsp_err !== e_err) begin
         fails++; $display("FAIL R11 rsp_err act=%0b exp=%0b", rsp_err, e_err);
      end
      if (bus_be_n !== e_be) begin
         fails++; $display("FAIL %s bus_be_n act=%b exp=%b", tag_be(), bus_be_n, e_be);
      end
      if (bus_dout !== e_dout) begin
         fails++; $display("FAIL %s bus_dout act=%h exp=%h", tag_dout(), bus_dout, e_dout);
      end
      if (int_rdata !== e_rdat) begin
         fails++; $display("FAIL %s int_rdata act=%h exp=%h", tag_rdat(), int_rdata, e_rdat);
      end
   endtask

   // One clock: check what the last drive produced, then drive anew
   task automatic step(input bit v, input int op, input int sz, input int ptr, input bit sw);
      logic [31:0] wd, rd;
      @(negedge clk);
      compare();
      wd = $urandom; rd = $urandom;
      req_valid = v; req_op = op[1:0]; req_size = sz[1:0]; req_ptr = ptr[1:0];
      swap_mode = sw; int_wdata = wd; bus_din = rd;
      if (v) model(op, sz, ptr, sw, wd, rd);
      else   e_valid = 0;   // outputs hold (R1)
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare();                 // reset state, R1
      rst_n = 1'b1;
      // Exhaustive sweep: R3..R12 across all codes
      for (int op = 0; op < 4; op++)
         for (int sz = 0; sz < 4; sz++)
            for (int p = 0; p < 4; p++)
               for (int s = 0; s < 2; s++) begin
                  if ($urandom % 3 == 0) step(0, 0, 0, 0, 0);
                  step(1, op, sz, p, s[0]);
               end
      // Random back-to-back and gapped traffic
      for (int i = 0; i < 600; i++)
         step(($urandom % 4) != 0, $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 2);
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule